// File: doc/BRIEF.md
# Systolic FIR Convolver Array

This block is a linear chain of identical multiply-accumulate stages that convolves a stream of signed 5-bit samples with a reloadable kernel of signed 6-bit taps. The current sample goes to every stage at once. Each stage multiplies the sample by its own tap, adds the product to the partial sum from the stage before it, and registers the total for the next stage. The last stage's register is the filter output, so each result passes through every stage, one stage per pipeline step. All sums are 12 bits wide and wrap modulo 2^12.

The kernel has no separate bus. With the multiply path switched off, the kernel values are pushed down the partial-sum chain from the first stage. One load strobe then makes every tap register copy the partial-sum register of the stage before it, so the whole kernel is latched at once. After loading, the pipeline is cleared. A valid flag marks outputs that rest entirely on real samples.

Top module: `fir_systolic_array`

## Requirements
- R1: Synchronous active-high reset sets y_out to 0, y_valid to 0 and every tap to 0. After reset, any samples give an output of 0.
- R2: With mac_en=1, each cycle with step_en=1 takes x_in as the newest sample x[n]. Stage k (1..N) registers prev_k + x[n]*h_k, where prev_1 is 0 and prev_k is stage k-1's register. So y_out = sum over k=1..N of h_k*x[n-N+k], which means h_N weights the newest sample.
- R3: On a cycle with coef_ld=1, tap h_1 takes k_in[5:0] and tap h_k (k>=2) takes the low 6 bits of stage k-1's register. The taps do not change on any other cycle.
- R4: With mac_en=0, every product is treated as zero and stage 1 takes k_in in place of 0. A value driven on k_in appears unchanged on y_out after N steps.
- R5: A cycle with step_en=0 and pipe_clr=0 leaves y_out and y_valid unchanged, whatever x_in, k_in or coef_ld are.
- R6: pipe_clr=1 sets every stage register to 0 and drops y_valid on the next cycle. It takes priority over step_en and leaves the taps unchanged.
- R7: y_valid is 1 once N steps with mac_en=1 have occurred since the last reset, clear or mac_en=0 step. It is 0 after any step with mac_en=0.
- R8: Products and sums are two's complement and wrap modulo 2^12 without saturation. For example, four taps of -32 and four samples of -16 give 12'h800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Pipeline advance enable |
| mac_en | input | 1 | Multiply path enable (0 during kernel shifting) |
| pipe_clr | input | 1 | Clear all stage registers and fill count |
| coef_ld | input | 1 | Latch taps from neighbouring stage registers |
| x_in | input | 5 | Signed input sample |
| k_in | input | 12 | Kernel value fed into stage 1 |
| y_out | output | 12 | Filter result (last stage register) |
| y_valid | output | 1 | Result is based on N real samples |

## Verification
The bench goes after tap ordering. A design that reverses the tap-to-stage mapping or loads taps from the wrong neighbour gives wrong dot products for asymmetric kernels, while symmetric ones still look right. Extreme kernels and samples reach exactly 2^11, so a design that saturates or truncates the product before sign extension shows a wrong value there. The bench also checks that a load strobe without a step leaves y_out intact, and that clearing and shifting with mac_en=0 keep the valid flag low. A fill counter that is off by one would raise y_valid one step early or late.

// File: rtl/sysconv_pkg.sv
package sysconv_pkg;
    localparam int SAMPLE_W = 5;
    localparam int COEF_W   = 6;
    localparam int SUM_W    = 12;
    localparam int PROD_W   = SAMPLE_W + COEF_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [SUM_W-1:0]    sum_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    typedef struct packed {
        sum_t  psum;
        coef_t coef;
    } cell_state_t;

    // One multiply-accumulate step; the product is dropped when en is low.
    function automatic sum_t mac_step(sum_t acc, sample_t x, coef_t c, logic en);
        prod_t p;
        p = x * c;
        return en ? sum_t'(acc + sum_t'(p)) : acc;
    endfunction
endpackage

// File: rtl/sysconv_cell.sv
module sysconv_cell
    import sysconv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    input  logic  mac_en,
    input  logic  pipe_clr,
    input  logic  coef_ld,
    input  sample_t x,
    input  sum_t  psum_prev,
    input  coef_t coef_src,
    output sum_t  psum
);
    cell_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (pipe_clr)
                st.psum <= '0;
            else if (step_en)
                st.psum <= mac_step(psum_prev, x, st.coef, mac_en);
            if (coef_ld)
                st.coef <= coef_src;
        end
    end

    assign psum = st.psum;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        pipe_clr |=> (psum == '0));
    // R5
    hold_psum_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !pipe_clr) |=> $stable(psum));
    // R3
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !coef_ld |=> $stable(st.coef));
endmodule

// File: rtl/sysconv_fill_ctr.sv
module sysconv_fill_ctr #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic mac_en,
    input  logic pipe_clr,
    output logic full
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LIMIT = CW'(N);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || pipe_clr)
            cnt <= '0;
        else if (step_en) begin
            if (!mac_en)
                cnt <= '0;
            else if (cnt != LIMIT)
                cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == LIMIT);

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
    // R7
    full_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(step_en && mac_en && !pipe_clr));
endmodule

// File: rtl/fir_systolic_array.sv
module fir_systolic_array
    import sysconv_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic                mac_en,
    input  logic                pipe_clr,
    input  logic                coef_ld,
    input  logic [SAMPLE_W-1:0] x_in,
    input  logic [SUM_W-1:0]    k_in,
    output logic [SUM_W-1:0]    y_out,
    output logic                y_valid
);
    sum_t  chain [N+1];
    coef_t csrc  [N+1];

    assign chain[0] = mac_en ? sum_t'(0) : sum_t'(k_in);
    assign csrc[0]  = coef_t'(k_in[COEF_W-1:0]);

    for (genvar i = 1; i <= N; i++) begin : g_stage
        if (i == 1) begin : g_head
            assign csrc[i] = csrc[0];
        end else begin : g_body
            assign csrc[i] = chain[i-1][COEF_W-1:0];
        end

        sysconv_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .step_en   (step_en),
            .mac_en    (mac_en),
            .pipe_clr  (pipe_clr),
            .coef_ld   (coef_ld),
            .x         (sample_t'(x_in)),
            .psum_prev (chain[i-1]),
            .coef_src  (csrc[i]),
            .psum      (chain[i])
        );
    end

    sysconv_fill_ctr #(.N(N)) u_fill (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .mac_en   (mac_en),
        .pipe_clr (pipe_clr),
        .full     (y_valid)
    );

    assign y_out = chain[N];

    // R7
    shift_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !mac_en) |=> !y_valid);
    // R6
    clr_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        pipe_clr |=> (!y_valid && y_out == '0));
    // R5
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !pipe_clr) |=> $stable(y_valid));
endmodule

// File: tb/fir_systolic_array_bench.sv
module fir_systolic_array_bench;
    localparam int N = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        step_en = 0, mac_en = 1, pipe_clr = 0, coef_ld = 0;
    logic [4:0]  x_in = '0;
    logic [11:0] k_in = '0;
    logic [11:0] y_out;
    logic        y_valid;

    int n_chk = 0;
    int n_fail = 0;

    logic signed [5:0] kh   [1:N];
    logic signed [4:0] hist [N];
    int nfill = 0;

    // Kernels: h1 in [5:0], h2 in [11:6], h3 in [17:12], h4 in [23:18]
    localparam logic [23:0] KTAB [6] = '{
        {6'sd4,  6'sd3,  6'sd2,  6'sd1},
        {6'sd1,  6'sd0,  6'sd0,  6'sd0},
        {6'sd0,  6'sd0,  6'sd0,  6'sd1},
        {6'h20,  6'h20,  6'h20,  6'h20},
        {6'sd31, -6'sd7, 6'sd12, -6'sd1},
        {-6'sd5, 6'sd17, -6'sd30, 6'sd9}
    };

    fir_systolic_array #(.N(N)) u_fir_systolic_array (
        .clk(clk), .rst(rst), .step_en(step_en), .mac_en(mac_en),
        .pipe_clr(pipe_clr), .coef_ld(coef_ld), .x_in(x_in), .k_in(k_in),
        .y_out(y_out), .y_valid(y_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic s, input logic m, input logic c, input logic l,
                        input logic [4:0] x, input logic [11:0] k);
        step_en = s; mac_en = m; pipe_clr = c; coef_ld = l; x_in = x; k_in = k;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [11:0] ref_y();
        int acc = 0;
        for (int k = 1; k <= N; k++)
            acc += int'(kh[k]) * int'(hist[N-k]);
        return acc[11:0];
    endfunction

    // R3 load sequence: shift h_N..h_2, strobe with h_1 on k_in, then clear
    task automatic load_kernel(input logic [23:0] kv);
        for (int k = 1; k <= N; k++) kh[k] = kv[(k-1)*6 +: 6];
        for (int k = N; k >= 2; k--)
            tick(1, 0, 0, 0, 5'd0, {{6{kh[k][5]}}, kh[k]});
        chk("R4 valid low while shifting", {31'd0, y_valid}, 0);
        tick(0, 0, 0, 1, 5'd0, {{6{kh[1][5]}}, kh[1]});
        tick(0, 1, 1, 0, 5'd0, 12'd0);
        chk("R6 clear output", {20'd0, y_out}, 0);
        chk("R6 clear valid", {31'd0, y_valid}, 0);
        nfill = 0;
    endtask

    task automatic push(input logic [4:0] x, input string tag);
        tick(1, 1, 0, 0, x, 12'd0);
        for (int j = N-1; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = x;
        if (nfill < N) nfill++;
        if (nfill == N) begin
            chk({tag, " valid"}, {31'd0, y_valid}, 1);
            chk(tag, {20'd0, y_out}, {20'd0, ref_y()});
        end else
            chk("R7 valid low during fill", {31'd0, y_valid}, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] hold_y;
        for (int j = 0; j < N; j++) hist[j] = '0;
        tick(0, 1, 0, 0, 5'd0, 12'd0);
        tick(0, 1, 0, 0, 5'd0, 12'd0);
        rst = 0;
        // R1 reset state
        chk("R1 reset y_out", {20'd0, y_out}, 0);
        chk("R1 reset valid", {31'd0, y_valid}, 0);
        for (int i = 0; i < N; i++) tick(1, 1, 0, 0, 5'h0F, 12'd0);
        chk("R1 zero taps give zero", {20'd0, y_out}, 0);
        chk("R7 valid after N steps", {31'd0, y_valid}, 1);

        // R4 shift path: value appears after N steps
        tick(0, 1, 1, 0, 5'd0, 12'd0);
        tick(1, 0, 0, 0, 5'd0, 12'h5A3);
        for (int i = 1; i < N; i++) tick(1, 0, 0, 0, 5'd0, 12'd0);
        chk("R4 shifted value", {20'd0, y_out}, 32'h5A3);
        chk("R4 valid low", {31'd0, y_valid}, 0);

        // R2 main table walk
        for (int t = 0; t < 6; t++) begin
            load_kernel(KTAB[t]);
            for (int i = 0; i < 24; i++) push(5'($urandom), "R2 dot product");
        end

        // R8 wrap: taps -32 samples -16 -> 12'h800
        load_kernel(KTAB[3]);
        for (int i = 0; i < N; i++) push(5'h10, "R8 wrap");
        chk("R8 wrap exact", {20'd0, y_out}, 32'h800);

        // R5 idle cycles, also with a load strobe
        load_kernel(KTAB[4]);
        for (int i = 0; i < N; i++) push(5'($urandom), "R2 dot product");
        hold_y = y_out;
        tick(0, 1, 0, 0, 5'h0B, 12'h3FF);
        tick(0, 1, 0, 1, 5'h13, 12'h155);
        chk("R5 y_out held", {20'd0, y_out}, {20'd0, hold_y});
        chk("R5 valid held", {31'd0, y_valid}, 1);

        // R6 clear priority over step
        tick(1, 1, 1, 0, 5'h07, 12'd0);
        chk("R6 clear beats step", {20'd0, y_out}, 0);
        chk("R6 clear drops valid", {31'd0, y_valid}, 0);

        // R3 taps kept across clear: reload known kernel and verify
        load_kernel(KTAB[5]);
        for (int j = 0; j < N; j++) hist[j] = '0;
        for (int i = 0; i < 10; i++) push(5'($urandom), "R3 loaded taps");

        // R7 a mac_en=0 step drops valid
        tick(1, 0, 0, 0, 5'd0, 12'd0);
        chk("R7 shift step drops valid", {31'd0, y_valid}, 0);

        // R1 reset mid-run
        rst = 1;
        tick(0, 1, 0, 0, 5'd0, 12'd0);
        rst = 0;
        for (int i = 0; i < N; i++) tick(1, 1, 0, 0, 5'h09, 12'd0);
        chk("R1 reset clears taps", {20'd0, y_out}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule